// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block makes a taken or not-taken guess for a branch at a fetch address. It does this by joining two pieces of context. A table of small saturating counters is split into rows. The low-order bits of the branch address pick the row. A short register of recent branch outcomes, shared by all branches, picks one counter inside that row. As a result, one branch reached along different recent paths trains different counters.

Lookup needs no clock. The front end presents a PC and gets back the guess together with the history value that was used to make it. The front end carries that history value along with the branch. When the branch resolves, it returns the PC, the real outcome and that saved history. On the next clock edge the selected counter moves one step toward the outcome, and the outcome enters the low end of the history register. Entries carry no tags, so branches whose index bits match share counters.

Top module: `gcp_predictor`

## Requirements
- R1: While reset is held and right after it is released, the history reads zero and every counter holds 2^(n-1)-1. With that value every lookup predicts not-taken.
- R2: Each accepted update shifts the history left by one bit and puts the outcome (1 = taken, 0 = not-taken) into bit 0. The oldest bit drops out. `lk_hist` shows the new value after the next rising clock edge.
- R3: The counter index is {pc[PC_SKIP +: ROW_BITS], history}. The address field selects the row and the m history bits select the counter within it. Lookup uses the current history.
- R4: The prediction is taken exactly when the selected counter is at least 2^(n-1).
- R5: A taken update adds one to the selected counter and holds at 2^n-1.
- R6: A not-taken update subtracts one from the selected counter and holds at 0.
- R7: An update selects its counter with `up_hist`, the history captured at prediction time, and not with the present history.
- R8: PC bits below PC_SKIP and above PC_SKIP+ROW_BITS do not affect the index. Branches that share the row field alias onto the same counters.
- R9: A single update changes only the counter it indexes. No other counter changes.
- R10: When `up_valid` is low, neither the history nor any counter changes.
- R11: The prediction follows `lk_pc` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address to predict |
| lk_taken | output | 1 | Prediction, 1 = taken |
| lk_hist | output | HIST_W | Current global history, to be saved with the branch |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_W | History captured when that branch was predicted |

## Verification
The assertions check these rules on every cycle:
- The history shifts in the outcome on every update and holds when there is none.
- The first state after reset is correct.
- The lookup and update index paths agree whenever their row fields and history values match, and the history fills the low bits of the index.

Only the bench scenarios can show the following, because the bench compares every lookup against its own arithmetic model of the whole table:
- counter saturation at both ends;
- the threshold decision;
- training with a stale history value;
- aliasing between addresses;
- the absence of side effects on counters that were not addressed.

Each scenario runs on the default (2,2) instance and on a (1,1) instance.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

    // One saturating step toward the outcome; top_v is the largest value.
    function automatic logic [31:0] sat_step(logic [31:0] v, logic up, logic [31:0] top_v);
        logic [31:0] r;
        r = v;
        if (up) begin
            if (v != top_v) r = v + 32'd1;
        end else begin
            if (v != 32'd0) r = v - 32'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/gcp_index.sv
module gcp_index #(
    parameter int PC_W     = 32,
    parameter int PC_SKIP  = 2,
    parameter int ROW_BITS = 8,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = ROW_BITS + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    // Row from the address, counter within the row from history.
    assign idx = {pc[PC_SKIP +: ROW_BITS], hist};
endmodule

// File: rtl/gcp_history.sv
module gcp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = HIST_W'({st_q.bits, shift_bit});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.bits;
endmodule

// File: rtl/gcp_ctr_table.sv
module gcp_ctr_table #(
    parameter int IDX_W   = 10,
    parameter int CTR_W   = 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import gcp_pkg::*;

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_WEAK = CTR_W'((1 << (CTR_W - 1)) - 1);

    typedef struct packed {
        logic [ENTRIES-1:0][CTR_W-1:0] ctr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.ctr[wr_idx] = CTR_W'(sat_step(32'(tbl_q.ctr[wr_idx]), wr_taken, 32'(CTR_MAX)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q.ctr[i] <= CTR_WEAK;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ctr = tbl_q.ctr[rd_idx];
endmodule

// File: rtl/gcp_predictor.sv
module gcp_predictor #(
    parameter int PC_W     = 32,
    parameter int PC_SKIP  = 2,
    parameter int ROW_BITS = 8,
    parameter int HIST_W   = 2,
    parameter int CTR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [HIST_W-1:0] up_hist
);
    localparam int IDX_W = ROW_BITS + HIST_W;
    localparam logic [CTR_W-1:0] CTR_HALF = CTR_W'(1 << (CTR_W - 1));

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [CTR_W-1:0] lk_ctr;
    logic [HIST_W-1:0] hist_cur;

    gcp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (up_valid),
        .shift_bit (up_taken),
        .hist      (hist_cur)
    );

    gcp_index #(.PC_W(PC_W), .PC_SKIP(PC_SKIP), .ROW_BITS(ROW_BITS), .HIST_W(HIST_W)) u_lk_index (
        .pc   (lk_pc),
        .hist (hist_cur),
        .idx  (lk_idx)
    );

    gcp_index #(.PC_W(PC_W), .PC_SKIP(PC_SKIP), .ROW_BITS(ROW_BITS), .HIST_W(HIST_W)) u_up_index (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    gcp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    assign lk_taken = (lk_ctr >= CTR_HALF);
    assign lk_hist  = hist_cur;
endmodule

// File: rtl/gcp_predictor_chk.sv
module gcp_predictor_chk #(
    parameter int PC_W     = 32,
    parameter int PC_SKIP  = 2,
    parameter int ROW_BITS = 8,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = ROW_BITS + HIST_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic [PC_W-1:0]   up_pc,
    input logic              up_taken,
    input logic [HIST_W-1:0] up_hist,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [IDX_W-1:0]  up_idx
);
    logic first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (lk_hist == '0) && !lk_taken);

    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

    // R10
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R3
    hist_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_idx[HIST_W-1:0] == lk_hist);

    // R8
    index_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_pc[PC_SKIP +: ROW_BITS] == up_pc[PC_SKIP +: ROW_BITS] && lk_hist == up_hist)
        |-> lk_idx == up_idx);
endmodule

bind gcp_predictor gcp_predictor_chk #(
    .PC_W(PC_W), .PC_SKIP(PC_SKIP), .ROW_BITS(ROW_BITS), .HIST_W(HIST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
    .lk_idx(lk_idx), .up_idx(up_idx)
);

// File: tb/gcp_predictor_tb.sv
module gcp_predictor_tb;
    localparam int AM = 2, AN = 2, AR = 8;
    localparam int BM = 1, BN = 1, BR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] lk_pc = '0, up_pc = '0;
    logic up_valid = 1'b0, up_taken = 1'b0;
    logic [AM-1:0] up_hist_a = '0;
    logic [BM-1:0] up_hist_b = '0;
    logic lk_taken_a, lk_taken_b;
    logic [AM-1:0] lk_hist_a;
    logic [BM-1:0] lk_hist_b;

    gcp_predictor #(.ROW_BITS(AR), .HIST_W(AM), .CTR_W(AN)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_a), .lk_hist(lk_hist_a),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist_a));

    gcp_predictor #(.ROW_BITS(BR), .HIST_W(BM), .CTR_W(BN)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_b), .lk_hist(lk_hist_b),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist_b));

    int ctr_a[1 << (AR + AM)];
    int ctr_b[1 << (BR + BM)];
    int hist_a, hist_b;
    int n_cmp = 0, n_bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic int idx_of(logic [31:0] pc, int h, int m, int r);
        return (int'((pc >> 2) & ((32'd1 << r) - 1)) << m) | h;
    endfunction

    function automatic int sat(int v, bit up, int n);
        if (up) return (v == (1 << n) - 1) ? v : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Lookup is combinational (R11): change lk_pc mid-cycle and compare.
    task automatic probe(string req, logic [31:0] pc);
        lk_pc = pc;
        #1;
        chk({req, " R4 pred(2,2)"}, int'(lk_taken_a), int'(ctr_a[idx_of(pc, hist_a, AM, AR)] >= (1 << (AN - 1))));
        chk({req, " R2 hist(2,2)"}, int'(lk_hist_a), hist_a);
        chk({req, " R4 pred(1,1)"}, int'(lk_taken_b), int'(ctr_b[idx_of(pc, hist_b, BM, BR)] >= (1 << (BN - 1))));
        chk({req, " R2 hist(1,1)"}, int'(lk_hist_b), hist_b);
    endtask

    // Called just after a falling edge; the update lands at the next rising edge.
    task automatic step(bit v, logic [31:0] pc, bit t, int ha, int hb);
        up_valid = v; up_pc = pc; up_taken = t;
        up_hist_a = AM'(ha); up_hist_b = BM'(hb);
        @(posedge clk);
        if (v) begin
            ctr_a[idx_of(pc, ha & 3, AM, AR)] = sat(ctr_a[idx_of(pc, ha & 3, AM, AR)], t, AN);
            ctr_b[idx_of(pc, hb & 1, BM, BR)] = sat(ctr_b[idx_of(pc, hb & 1, BM, BR)], t, BN);
            hist_a = ((hist_a << 1) | int'(t)) & 3;
            hist_b = int'(t);
        end
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        foreach (ctr_a[i]) ctr_a[i] = (1 << (AN - 1)) - 1;
        foreach (ctr_b[i]) ctr_b[i] = (1 << (BN - 1)) - 1;
        hist_a = 0; hist_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: every row reads weakly not-taken, history zero
        for (int r = 0; r < (1 << AR); r++) probe("R1 reset", 32'(r << 2));

        // R9: one taken update from reset touches one counter only
        step(1'b1, 32'h0000_0100, 1'b1, 0, 0);
        for (int r = 0; r < (1 << AR); r++) probe("R9 isolation", 32'(r << 2));

        // R10: idle cycles with live-looking update inputs change nothing
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 32'h0000_0100, 1'b1, 1, 1);
            probe("R10 no update", 32'h0000_0100);
        end

        // R5: drive one entry to the top and past it
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 32'h0000_0200, 1'b1, 3, 1);
            probe("R5 sat high", 32'h0000_0200);
        end
        step(1'b1, 32'h0000_0200, 1'b0, 3, 1);
        probe("R5 after max", 32'h0000_0200);

        // R6: drive one entry to the bottom and past it
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 32'h0000_0300, 1'b0, 0, 0);
            probe("R6 sat low", 32'h0000_0300);
        end
        step(1'b1, 32'h0000_0300, 1'b1, 0, 0);
        probe("R6 after min", 32'h0000_0300);

        // R3/R7: train each history slot of one row with its own outcome,
        // always naming the slot explicitly rather than the live history
        for (int h = 0; h < 4; h++) begin
            for (int k = 0; k < 3; k++) step(1'b1, 32'h0000_0040, (h % 2) == 1, h, h % 2);
        end
        for (int k = 0; k < 4; k++) begin
            probe("R3 per-history slot", 32'h0000_0040);
            step(1'b1, 32'h0000_0800, k[0], 0, 0);
        end

        // R8: aliases differing only in ignored bits
        for (int k = 0; k < 16; k++) begin
            probe("R8 alias", 32'h0000_0200 | (32'(k) << 20) | 32'(k & 3));
        end

        // Mixed sweep with stale histories (R7) and gaps (R10)
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] pc;
            lfsr = nxt(lfsr);
            pc = {lfsr[31:20], 10'd0, 2'd0, 3'd0, lfsr[4:0]} << 0;
            pc = (pc & 32'hFFF0_0000) | (32'(lfsr[5:2]) << 2) | 32'(lfsr[1:0]);
            probe("R7 mixed", pc);
            probe("R11 second lookup", {lfsr[15:8], 24'(lfsr[27:16]) << 2});
            step(lfsr[6] | lfsr[7], pc, lfsr[8] | lfsr[9],
                 lfsr[10] ? int'(lfsr[12:11]) : hist_a,
                 lfsr[13] ? int'(lfsr[14]) : hist_b);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule